// File: doc/BRIEF.md
# Fault Input Shutdown Controller

This block guards a set of six pulse-width outputs against an external fault. It watches an active-low fault pin. When the pin is asserted and the guard is armed, every output is forced to a safe level that software has chosen, bit by bit. When the guard is not armed, the outputs simply repeat the waveform from an external generator. Each accepted fault onset also latches a sticky interrupt flag, and the flag drives an interrupt request until software clears it.

The fault pin first crosses into the clock domain through a two-flop synchronizer. It then either goes straight to the override logic or passes through a persistence filter. The filter counts consecutive low cycles and accepts the fault only when its n-bit counter overflows. A two-bit select sets n to 2, 3, 4 or 5, so shorter glitches are rejected. A byte-wide control port holds the arm bit, the flag, the filter enable and the length select. Reads of that port have a read-modify-write form, which reports the flag as 1 so that a write-back of the read value never clears it by accident.

Top module: `fault_shutdown_ctrl`

## Requirements
- R1: After reset, the control byte reads 0x00, `irq` is 0, and `pwm_out` equals `pwm_in`.
- R2: While the arm bit (control bit 0) is 0, `pwm_out` equals `pwm_in` and a fault never sets the flag.
- R3: While armed, each accepted falling edge of the filtered fault level sets the flag (control bit 1) one cycle after the override starts, and `irq` equals flag AND arm.
- R4: A control write with bit 1 = 0 clears the flag, and a write with bit 1 = 1 leaves it unchanged. If a flag set and a clearing write fall in the same cycle, the flag ends up 1.
- R5: When `ctl_rd_rmw` is 1, `ctl_rdata` bit 1 reads 1 whatever the flag holds. The other fields read their real values.
- R6: With the filter off (control bit 2 = 0), a raw low first sampled at clock edge k puts `pwm_out` at the safe levels from edge k+2.
- R7: With the filter on, n = 2 + control bits [4:3]. A raw low held for L consecutive sampled cycles is accepted only if L >= 2^n, and then the override starts from edge k+2^n+1. A shorter low changes neither the outputs nor the flag.
- R8: During an accepted armed fault, `pwm_out[i]` equals `safe_lvl[i]`. The outputs return to `pwm_in` two edges after the raw pin is first sampled high again, whatever the flag holds.
- R9: Control byte layout: bit 0 arm, bit 1 flag, bit 2 filter enable, bits [4:3] length select, bits [7:5] read 0. A write loads bits 0, 2 and [4:3] directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_n_raw | input | 1 | Asynchronous active-low fault pin |
| pwm_in | input | 6 | Waveform bits from the generator |
| safe_lvl | input | 6 | Safe level for each output during a fault |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rd_rmw | input | 1 | Marks the current read as read-modify-write |
| ctl_rdata | output | 8 | Control byte read data |
| pwm_out | output | 6 | Gated outputs |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle. An unarmed block passes its waveform through, and an armed fault drives the safe levels. The flag obeys its clear and hold rules, including the win of a set over a clearing write. A read-modify-write read shows the flag as 1. The filtered level only falls after a synchronized low, and in bypass it tracks the synchronizer. Only the bench's scenarios can show the exact acceptance boundary of 2^n cycles and the onset and release latencies for every filter length. The same holds for the rejection of glitches one cycle short of that boundary and for the flag's value after each pulse.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
   localparam int CTL_W      = 8;
   localparam int BIT_ARM    = 0;
   localparam int BIT_FLAG   = 1;
   localparam int BIT_FILT   = 2;
   localparam int BIT_SEL_LO = 3;
   localparam int SEL_W      = 2;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             filt;
      logic             flag;
      logic             arm;
   } ctl_t;
endpackage

// File: rtl/fsc_sync.sv
module fsc_sync #(
   parameter int STAGES = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsc_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/fsc_filter.sv
module fsc_filter #(
   parameter int N_MIN      = 2,
   parameter int SEL_W      = 2,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             use_filt,
   input  logic [SEL_W-1:0] sel,
   output logic             lvl
);
   localparam int N_MAX = N_MIN + (1 << SEL_W) - 1;
   localparam int CNT_W = N_MAX;

   generate
      if (N_MIN < 1) begin : g_bad_nmin
         $error("fsc_filter N_MIN must be at least 1");
      end
      if (N_MAX > 24) begin : g_bad_nmax
         $error("fsc_filter counter too wide");
      end
   endgenerate

   generate
      if (HAS_FILTER) begin : g_filter
         logic [CNT_W-1:0] cnt;
         logic [CNT_W:0]   full;
         logic [CNT_W-1:0] limit;
         logic             lvl_q;

         always_comb begin
            full  = {{CNT_W{1'b0}}, 1'b1} << (N_MIN + int'(sel));
            limit = CNT_W'(full - 1'b1);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt   <= '0;
               lvl_q <= 1'b1;
            end else if (!use_filt) begin
               cnt   <= '0;
               lvl_q <= din;
            end else if (din) begin
               cnt   <= '0;
               lvl_q <= 1'b1;
            end else if (lvl_q) begin
               if (cnt == limit) begin
                  cnt   <= '0;
                  lvl_q <= 1'b0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end

         assign lvl = lvl_q;
      end else begin : g_bypass
         logic lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b1;
            else        lvl_q <= din;
         end
         assign lvl = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/fsc_ctl_reg.sv
module fsc_ctl_reg
   import fsc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wdata,
   input  logic             rd_rmw,
   input  logic             set_ev,
   output ctl_t             ctl,
   output logic [CTL_W-1:0] rdata
);
   ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (wr_en) begin
            ctl_q.arm  <= wdata[BIT_ARM];
            ctl_q.filt <= wdata[BIT_FILT];
            ctl_q.sel  <= wdata[BIT_SEL_LO +: SEL_W];
         end
         if (set_ev)                        ctl_q.flag <= 1'b1;
         else if (wr_en && !wdata[BIT_FLAG]) ctl_q.flag <= 1'b0;
      end
   end

   always_comb begin
      rdata                        = '0;
      rdata[BIT_ARM]               = ctl_q.arm;
      rdata[BIT_FLAG]              = ctl_q.flag | rd_rmw;
      rdata[BIT_FILT]              = ctl_q.filt;
      rdata[BIT_SEL_LO +: SEL_W]   = ctl_q.sel;
   end

   assign ctl = ctl_q;
endmodule

// File: rtl/fault_shutdown_ctrl.sv
module fault_shutdown_ctrl
   import fsc_pkg::*;
#(
   parameter int N_OUT       = 6,
   parameter int SYNC_STAGES = 2,
   parameter int N_MIN       = 2,
   parameter bit HAS_FILTER  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fault_n_raw,
   input  logic [N_OUT-1:0] pwm_in,
   input  logic [N_OUT-1:0] safe_lvl,
   input  logic             ctl_wr_en,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             ctl_rd_rmw,
   output logic [CTL_W-1:0] ctl_rdata,
   output logic [N_OUT-1:0] pwm_out,
   output logic             irq
);
   generate
      if (N_OUT < 1) begin : g_bad_nout
         $error("fault_shutdown_ctrl needs at least one output");
      end
   endgenerate

   ctl_t ctl;
   logic sync_lvl;
   logic flt_lvl;
   logic flt_d;
   logic set_ev;
   logic override;

   fsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (fault_n_raw),
      .dout (sync_lvl)
   );

   fsc_filter #(.N_MIN(N_MIN), .SEL_W(SEL_W), .HAS_FILTER(HAS_FILTER)) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (sync_lvl),
      .use_filt(ctl.filt),
      .sel     (ctl.sel),
      .lvl     (flt_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flt_d <= 1'b1;
      else        flt_d <= flt_lvl;
   end

   assign set_ev = flt_d & ~flt_lvl & ctl.arm;

   fsc_ctl_reg u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (ctl_wr_en),
      .wdata (ctl_wdata),
      .rd_rmw(ctl_rd_rmw),
      .set_ev(set_ev),
      .ctl   (ctl),
      .rdata (ctl_rdata)
   );

   assign override = ctl.arm & ~flt_lvl;

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_out
         assign pwm_out[i] = override ? safe_lvl[i] : pwm_in[i];
      end
   endgenerate

   assign irq = ctl.flag & ctl.arm;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
   parameter int N_OUT = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm,
   input logic             filt,
   input logic             flag,
   input logic             flt_lvl,
   input logic             sync_lvl,
   input logic             set_ev,
   input logic             wr_en,
   input logic [7:0]       wdata,
   input logic             rd_rmw,
   input logic [7:0]       rdata,
   input logic [N_OUT-1:0] pwm_in,
   input logic [N_OUT-1:0] safe_lvl,
   input logic [N_OUT-1:0] pwm_out,
   input logic             irq
);
   p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |-> pwm_out == pwm_in);

   p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !flt_lvl) |-> pwm_out == safe_lvl);

   p_irq_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> arm);

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wdata[1] && !set_ev) |=> !flag);

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[1] && flag) |=> flag);

   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> flag);

   p_rmw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rmw |-> rdata[1]);

   p_fall_after_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flt_lvl) |-> $past(!sync_lvl));

   p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!filt) && !filt) |-> flt_lvl == $past(sync_lvl));
endmodule

bind fault_shutdown_ctrl fsc_checker #(.N_OUT(N_OUT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .arm     (ctl.arm),
   .filt    (ctl.filt),
   .flag    (ctl.flag),
   .flt_lvl (flt_lvl),
   .sync_lvl(sync_lvl),
   .set_ev  (set_ev),
   .wr_en   (ctl_wr_en),
   .wdata   (ctl_wdata),
   .rd_rmw  (ctl_rd_rmw),
   .rdata   (ctl_rdata),
   .pwm_in  (pwm_in),
   .safe_lvl(safe_lvl),
   .pwm_out (pwm_out),
   .irq     (irq)
);

// File: tb/fault_shutdown_ctrl_bench.sv
module fault_shutdown_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fault_n_raw = 1'b1;
   logic [5:0] pwm_in = 6'h00;
   logic [5:0] safe_lvl = 6'h00;
   logic       ctl_wr_en = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic       ctl_rd_rmw = 1'b0;
   logic [7:0] ctl_rdata;
   logic [5:0] pwm_out;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   fault_shutdown_ctrl u_fault_shutdown_ctrl (
      .clk(clk), .rst_n(rst_n), .fault_n_raw(fault_n_raw),
      .pwm_in(pwm_in), .safe_lvl(safe_lvl),
      .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_rd_rmw(ctl_rd_rmw),
      .ctl_rdata(ctl_rdata), .pwm_out(pwm_out), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // R9 layout: {3'b0, sel[1:0], filt, flag, arm}
   task automatic wr_ctl(input logic [7:0] v);
      ctl_wdata = v;
      ctl_wr_en = 1'b1;
      @(negedge clk);
      ctl_wr_en = 1'b0;
   endtask

   task automatic run_pulse(input int len, input bit filt, input int sel,
                            input logic [5:0] pat);
      int  t;
      bit  acc;
      bit  ov;
      pwm_in   = pat;
      safe_lvl = ~pat;
      wr_ctl({3'b000, 2'(sel), filt, 1'b0, 1'b1});
      t   = filt ? (1 << (2 + sel)) + 1 : 2;
      acc = filt ? (len >= (1 << (2 + sel))) : 1'b1;
      fault_n_raw = 1'b0;
      for (int j = 0; j <= len + 3; j++) begin
         @(negedge clk);
         ov = acc && (j >= t) && (j <= len + 1);
         chk(filt ? "R7" : "R6", {2'b00, pwm_out}, {2'b00, ov ? ~pat : pat});
         if (j == len - 1) fault_n_raw = 1'b1;
      end
      chk("R3", {7'd0, ctl_rdata[1]}, {7'd0, acc});
      chk("R3", {7'd0, irq}, {7'd0, acc});
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      pwm_in = 6'h2B;
      safe_lvl = 6'h14;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", ctl_rdata, 8'h00);
      chk("R1", {7'd0, irq}, 8'h00);
      chk("R1", {2'b00, pwm_out}, {2'b00, pwm_in});
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", ctl_rdata, 8'h00);

      // R2: unarmed, long fault, outputs follow and no flag
      wr_ctl(8'h00);
      fault_n_raw = 1'b0;
      for (int j = 0; j < 8; j++) begin
         pwm_in = 6'(j * 7);
         @(negedge clk);
         chk("R2", {2'b00, pwm_out}, {2'b00, pwm_in});
      end
      fault_n_raw = 1'b1;
      repeat (4) @(negedge clk);
      chk("R2", ctl_rdata, 8'h00);
      chk("R2", {7'd0, irq}, 8'h00);

      // R9: field readback
      wr_ctl(8'b000_10_1_0_1);
      chk("R9", ctl_rdata, 8'b000_10_1_0_1);
      wr_ctl(8'hE0);
      chk("R9", ctl_rdata, 8'h00);

      // R6 / R3 / R8: bypass mode sweep
      for (int len = 1; len <= 4; len++)
         run_pulse(len, 1'b0, 0, 6'(6'h15 + len));

      // R7 / R8: filter sweep over all lengths, both sides of the boundary
      for (int sel = 0; sel < 4; sel++)
         for (int len = 1; len <= (1 << (2 + sel)) + 2; len++)
            run_pulse(len, 1'b1, sel, 6'(6'h09 * len + sel));

      // R4: hold on write-1, clear on write-0
      run_pulse(3, 1'b0, 0, 6'h33);
      wr_ctl(8'b000_00_0_1_1);
      chk("R4", {7'd0, ctl_rdata[1]}, 8'h01);
      chk("R4", {7'd0, irq}, 8'h01);
      // R5: read-modify-write form shows flag as 1
      wr_ctl(8'b000_01_0_0_1);
      chk("R4", {7'd0, ctl_rdata[1]}, 8'h00);
      chk("R4", {7'd0, irq}, 8'h00);
      ctl_rd_rmw = 1'b1;
      #1;
      chk("R5", ctl_rdata, 8'b000_01_0_1_1);
      ctl_rd_rmw = 1'b0;
      #1;
      chk("R5", ctl_rdata, 8'b000_01_0_0_1);

      // R4: set and clearing write in the same cycle, bypass mode
      wr_ctl(8'b000_00_0_0_1);
      fault_n_raw = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8", {2'b00, pwm_out}, {2'b00, safe_lvl});
      ctl_wdata = 8'b000_00_0_0_1;
      ctl_wr_en = 1'b1;
      @(negedge clk);
      ctl_wr_en = 1'b0;
      chk("R4", {7'd0, ctl_rdata[1]}, 8'h01);
      chk("R3", {7'd0, irq}, 8'h01);
      fault_n_raw = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8", {2'b00, pwm_out}, {2'b00, pwm_in});
      // R3: disarming masks irq but keeps the flag
      wr_ctl(8'b000_00_0_1_0);
      chk("R3", {7'd0, irq}, 8'h00);
      chk("R3", {7'd0, ctl_rdata[1]}, 8'h01);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule